// File: doc/BRIEF.md
# Link Power Mode Controller

This block decides whether a serial display link is off, idling or transmitting. An active-low shutdown pin puts it in shutdown. While the pin is released, the block watches the incoming pixel clock against a free-running reference clock. A stopped pixel clock keeps the link in standby. A pixel clock that is toggling moves the link to active. In active, the datapath reset is first held for a fixed number of reference cycles, and then the serial lanes are released from high impedance.

Clock activity is measured in the reference domain. Each rising pixel-clock edge flips a flag. The flag passes through a two-flop synchroniser, and its changes are counted over fixed windows of reference cycles. At the close of a window, the detect flag is set if the count reached the threshold. It is cleared if the count was zero. For a count in between, the flag keeps its value. The shutdown pin is synchronised with an asynchronous assertion, so pulling it low clears every register in the reference domain at once. Releasing it takes effect two reference edges later.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While the shutdown input is low, and no later than two reference edges after it falls, the mode output reads shutdown (2'b00), the clock-detect output is 0, the lane enable is 0 and the datapath reset is 1.
- R2: Three reference edges after the shutdown input rises, the mode output reads standby (2'b01), with the lane enable at 0 and the datapath reset at 1.
- R3: When the pixel clock starts toggling at more than MIN_TOG rising edges per window, the clock-detect output rises within 2*WIN_CYC+4 reference cycles.
- R4: On the edge after the clock-detect output rises, the mode output reads active (2'b10) while the datapath reset stays at 1 and the lanes stay disabled. The lane enable rises, and the datapath reset falls, exactly RST_HOLD+1 edges after the detect rise.
- R5: When the pixel clock stops while the block is active, the clock-detect output falls within 2*WIN_CYC+4 cycles. On the next edge the mode returns to standby, with the lanes disabled and the datapath reset asserted.
- R6: A pixel clock that gives fewer than MIN_TOG rising edges in every window is never flagged as running.
- R7: The clock-detect output changes only at window boundaries. From the cycle it rises, it holds for a whole number of windows, and for at least one window.
- R8: Shutdown asserted while the block is active overrides everything. After release, the block re-enters standby with the detector cleared, and then returns to active through a new detection.
- R9: A pixel clock held static at either level counts as stopped: standby persists and the clock-detect output stays or becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock for the controller |
| pix_clk | input | 1 | Incoming pixel clock whose activity is judged |
| shdn_n | input | 1 | Asynchronous active-low shutdown request |
| mode_o | output | 2 | Power mode: 00 shutdown, 01 standby, 10 active |
| clk_det_o | output | 1 | 1 while the pixel clock is judged to be running |
| lane_oe_o | output | 1 | 1 enables the serial lane drivers, 0 keeps them high impedance |
| dp_rst_o | output | 1 | Synchronous reset for the serialising datapath |

## Verification
Two functions can land on the same reference edge. One is the asynchronous shutdown override. The other is a detector window verdict, or the end of the reset hold. The bench pulls the shutdown input low while the block is active and the pixel clock is still running, so window closes keep arriving. It then judges that shutdown outputs appear within two edges and that detection restarts from zero after release. A second collision is a loss verdict against a wake that is still in progress: the bench stops the pixel clock on the cycle detection is flagged. It then checks that the flag drops on an exact window multiple and that the mode falls back to standby.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;

  typedef enum logic [1:0] {
    MODE_SHUT = 2'b00,
    MODE_STBY = 2'b01,
    MODE_ACT  = 2'b10
  } pmc_mode_e;

  typedef enum logic [1:0] {
    ST_SHUT,
    ST_STBY,
    ST_WAKE,
    ST_RUN
  } pmc_state_e;

  // externally visible mode for an internal state (wake counts as active)
  function automatic pmc_mode_e mode_of(input pmc_state_e s);
    case (s)
      ST_STBY:         return MODE_STBY;
      ST_WAKE, ST_RUN: return MODE_ACT;
      default:         return MODE_SHUT;
    endcase
  endfunction

  // edge tally with saturation at cap
  function automatic int unsigned sat_add(input int unsigned cur, input logic inc,
                                          input int unsigned cap);
    int unsigned sum;
    sum = cur + (inc ? 1 : 0);
    return (sum > cap) ? cap : sum;
  endfunction

  // verdict at window close: enough edges -> running, none -> stopped, else keep
  function automatic logic window_verdict(input int unsigned seen, input int unsigned need,
                                          input logic prev);
    if (seen >= need) return 1'b1;
    if (seen == 0)    return 1'b0;
    return prev;
  endfunction

endpackage

// File: rtl/pmc_sync.sv
`timescale 1ns/1ps
module pmc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pmc_clk_mon.sv
`timescale 1ns/1ps
module pmc_clk_mon
  import pmc_pkg::*;
#(
  parameter int WIN_CYC     = 32,
  parameter int MIN_TOG     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic shdn_n,
  input  logic pix_clk,
  output logic running_o,
  output logic win_end_o
);
  localparam int CW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
  localparam int TW = $clog2(MIN_TOG + 1);

  // pixel-domain toggle flag, cleared by the raw shutdown pin
  logic tog_pix;
  always_ff @(posedge pix_clk or negedge shdn_n) begin
    if (!shdn_n) tog_pix <= 1'b0;
    else         tog_pix <= ~tog_pix;
  end

  logic tog_s;
  pmc_sync #(.STAGES(SYNC_STAGES)) u_tog_sync (
    .clk    (ref_clk),
    .arst_n (rst_n),
    .d      (tog_pix),
    .q      (tog_s)
  );

  logic          tog_d;
  logic          edge_seen;
  logic [CW-1:0] win_cnt;
  logic [TW-1:0] tog_cnt;
  logic [TW-1:0] tally;
  logic          running;

  assign edge_seen = tog_s ^ tog_d;
  assign win_end_o = (win_cnt == CW'(WIN_CYC - 1));
  assign tally     = TW'(sat_add(int'(tog_cnt), edge_seen, MIN_TOG));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_d   <= 1'b0;
      win_cnt <= '0;
      tog_cnt <= '0;
      running <= 1'b0;
    end else begin
      tog_d <= tog_s;
      if (win_end_o) begin
        win_cnt <= '0;
        tog_cnt <= '0;
        running <= window_verdict(int'(tally), MIN_TOG, running);
      end else begin
        win_cnt <= win_cnt + CW'(1);
        tog_cnt <= tally;
      end
    end
  end

  assign running_o = running;
endmodule

// File: rtl/pmc_mode_fsm.sv
`timescale 1ns/1ps
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter int RST_HOLD = 8
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       running,
  output logic [1:0] mode_o,
  output logic       lane_oe_o,
  output logic       dp_rst_o
);
  localparam int HW = (RST_HOLD > 1) ? $clog2(RST_HOLD + 1) : 1;

  pmc_state_e    state, nxt;
  logic [HW-1:0] hold_cnt;
  logic          hold_done;

  assign hold_done = (hold_cnt == HW'(RST_HOLD - 1));

  always_comb begin
    nxt = state;
    case (state)
      ST_SHUT: nxt = ST_STBY;
      ST_STBY: if (running) nxt = ST_WAKE;
      ST_WAKE: begin
        if (!running)       nxt = ST_STBY;
        else if (hold_done) nxt = ST_RUN;
      end
      ST_RUN:  if (!running) nxt = ST_STBY;
      default: nxt = ST_SHUT;
    endcase
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_SHUT;
      hold_cnt <= '0;
    end else begin
      state    <= nxt;
      hold_cnt <= (state == ST_WAKE) ? hold_cnt + HW'(1) : '0;
    end
  end

  assign mode_o    = mode_of(state);
  assign lane_oe_o = (state == ST_RUN);
  assign dp_rst_o  = (state != ST_RUN);
endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl #(
  parameter int WIN_CYC     = 32,
  parameter int MIN_TOG     = 4,
  parameter int RST_HOLD    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       ref_clk,
  input  logic       pix_clk,
  input  logic       shdn_n,
  output logic [1:0] mode_o,
  output logic       clk_det_o,
  output logic       lane_oe_o,
  output logic       dp_rst_o
);
  // named internal events, observed by the bound checker
  logic core_rst_n;
  logic mon_running;
  logic mon_win_end;

  // assert asynchronously, release after SYNC_STAGES reference edges
  pmc_sync #(.STAGES(SYNC_STAGES)) u_shdn_sync (
    .clk    (ref_clk),
    .arst_n (shdn_n),
    .d      (1'b1),
    .q      (core_rst_n)
  );

  pmc_clk_mon #(
    .WIN_CYC     (WIN_CYC),
    .MIN_TOG     (MIN_TOG),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_mon (
    .ref_clk   (ref_clk),
    .rst_n     (core_rst_n),
    .shdn_n    (shdn_n),
    .pix_clk   (pix_clk),
    .running_o (mon_running),
    .win_end_o (mon_win_end)
  );

  pmc_mode_fsm #(.RST_HOLD(RST_HOLD)) u_fsm (
    .ref_clk   (ref_clk),
    .rst_n     (core_rst_n),
    .running   (mon_running),
    .mode_o    (mode_o),
    .lane_oe_o (lane_oe_o),
    .dp_rst_o  (dp_rst_o)
  );

  assign clk_det_o = mon_running;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_chk
  import pmc_pkg::*;
#(
  parameter int RST_HOLD = 8
) (
  input logic       ref_clk,
  input logic       rst_n,
  input logic       win_end,
  input logic [1:0] mode_o,
  input logic       clk_det_o,
  input logic       lane_oe_o,
  input logic       dp_rst_o
);
  logic [15:0] wake_len;
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                                      wake_len <= '0;
    else if (mode_o == MODE_ACT && dp_rst_o)          wake_len <= wake_len + 16'd1;
    else                                             wake_len <= '0;
  end

  // R1: core held in reset shows shutdown outputs
  a_r1_shutdown_outputs: assert property (@(posedge ref_clk)
    !rst_n |-> (mode_o == MODE_SHUT && !clk_det_o && !lane_oe_o && dp_rst_o));

  // R4: detection leads to active with reset still held
  a_r4_wake_after_det: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(clk_det_o) |=> (mode_o == MODE_ACT && dp_rst_o && !lane_oe_o));

  // R4: lanes enable only after exactly RST_HOLD wake cycles
  a_r4_hold_length: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(lane_oe_o) |-> (wake_len == 16'(RST_HOLD)));

  // R5: losing the clock drops to standby next edge
  a_r5_standby_after_loss: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(clk_det_o) |=> (mode_o == MODE_STBY && !lane_oe_o && dp_rst_o));

  // R7: detect flag moves only on a window close
  a_r7_det_at_window_end: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (clk_det_o != $past(clk_det_o)) |-> $past(win_end));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.RST_HOLD(RST_HOLD)) u_chk (
  .ref_clk   (ref_clk),
  .rst_n     (core_rst_n),
  .win_end   (mon_win_end),
  .mode_o    (mode_o),
  .clk_det_o (clk_det_o),
  .lane_oe_o (lane_oe_o),
  .dp_rst_o  (dp_rst_o)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
  localparam int REF_PERIOD = 10;
  localparam int WIN        = 32;
  localparam int NTOG       = 4;
  localparam int HOLD       = 8;
  localparam int LIMIT      = 2 * WIN + 4;

  logic ref_clk = 1'b0;
  logic pix_clk = 1'b0;
  logic shdn_n  = 1'b1;
  logic pix_run = 1'b0;
  logic pix_lvl = 1'b0;
  int   pix_half = 20;

  logic [1:0] mode_o;
  logic       clk_det_o, lane_oe_o, dp_rst_o;

  always #(REF_PERIOD / 2) ref_clk = ~ref_clk;

  initial forever begin
    if (pix_run) begin
      #(pix_half);
      if (pix_run) pix_clk = ~pix_clk;
    end else begin
      pix_clk = pix_lvl;
      #1;
    end
  end

  pwr_mode_ctrl #(.WIN_CYC(WIN), .MIN_TOG(NTOG), .RST_HOLD(HOLD)) dut_i (
    .ref_clk   (ref_clk),
    .pix_clk   (pix_clk),
    .shdn_n    (shdn_n),
    .mode_o    (mode_o),
    .clk_det_o (clk_det_o),
    .lane_oe_o (lane_oe_o),
    .dp_rst_o  (dp_rst_o)
  );

  typedef struct {
    string      tag;
    logic [4:0] val;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // driver side: queue the expected {mode, det, oe, rst}
  task automatic expect_out(input string tag, input logic [1:0] m, input logic d,
                            input logic o, input logic r);
    exp_t e;
    e.tag = tag;
    e.val = {m, d, o, r};
    exp_q.push_back(e);
  endtask

  // monitor side: compare away from the active edge
  always @(negedge ref_clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if ({mode_o, clk_det_o, lane_oe_o, dp_rst_o} !== e.val) begin
        n_err++;
        $display("FAIL %s: got %b expected %b", e.tag,
                 {mode_o, clk_det_o, lane_oe_o, dp_rst_o}, e.val);
      end
    end
  end

  task automatic check_cond(input string tag, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge ref_clk);
    #1;
  endtask

  task automatic wait_det(input logic lvl, output int n);
    n = 0;
    while (clk_det_o !== lvl && n <= LIMIT + 10) begin
      step(1);
      n++;
    end
  endtask

  initial begin
    int n;
    int rises;
    #1 shdn_n = 1'b0;
    step(5);
    expect_out("R1 shutdown at start", 2'b00, 0, 0, 1);

    @(negedge ref_clk) shdn_n = 1'b1;
    step(3);
    expect_out("R2 standby after release", 2'b01, 0, 0, 1);
    step(80);
    expect_out("R9 static low stays standby", 2'b01, 0, 0, 1);

    // R6: one edge per 400 ns, under NTOG per 320 ns window
    pix_half = 200;
    pix_run  = 1'b1;
    rises = 0;
    repeat (300) begin
      step(1);
      if (clk_det_o) rises++;
    end
    check_cond("R6 slow clock flagged", rises == 0, rises, 0);
    expect_out("R6 slow clock keeps standby", 2'b01, 0, 0, 1);
    pix_run = 1'b0;
    pix_lvl = 1'b0;
    step(80);

    // R3 / R4: fast clock, detect then wake
    pix_half = 20;
    pix_run  = 1'b1;
    wait_det(1'b1, n);
    check_cond("R3 detect latency", n > 0 && n <= LIMIT, n, LIMIT);
    expect_out("R3 detect raised in standby", 2'b01, 1, 0, 1);
    step(1);
    expect_out("R4 wake holds reset", 2'b10, 1, 0, 1);
    n = 0;
    while (!lane_oe_o && n < HOLD + 20) begin
      step(1);
      n++;
    end
    check_cond("R4 reset hold length", n == HOLD, n, HOLD);
    expect_out("R4 lanes enabled", 2'b10, 1, 1, 0);
    step(100);
    expect_out("R4 active steady", 2'b10, 1, 1, 0);

    // R5: stop low
    pix_run = 1'b0;
    pix_lvl = 1'b0;
    wait_det(1'b0, n);
    check_cond("R5 loss latency", n > 0 && n <= LIMIT, n, LIMIT);
    expect_out("R5 detect dropped", 2'b10, 0, 1, 0);
    step(1);
    expect_out("R5 back to standby", 2'b01, 0, 0, 1);

    // R9: stop high
    pix_run = 1'b1;
    wait_det(1'b1, n);
    step(HOLD + 1);
    expect_out("R9 active before high stop", 2'b10, 1, 1, 0);
    pix_lvl = 1'b1;
    pix_run = 1'b0;
    wait_det(1'b0, n);
    check_cond("R9 static high loss latency", n > 0 && n <= LIMIT, n, LIMIT);
    step(1);
    expect_out("R9 standby after high stop", 2'b01, 0, 0, 1);
    step(80);
    expect_out("R9 static high stays standby", 2'b01, 0, 0, 1);

    // R7: stop on the detect cycle, flag must fall on a window multiple
    pix_run = 1'b1;
    wait_det(1'b1, n);
    pix_run = 1'b0;
    wait_det(1'b0, n);
    check_cond("R7 detect held whole windows", n >= WIN && (n % WIN) == 0, n, WIN);
    step(1);
    expect_out("R7 standby after short run", 2'b01, 0, 0, 1);

    // R8: shutdown while active with clock still running
    pix_run = 1'b1;
    wait_det(1'b1, n);
    step(HOLD + 1);
    expect_out("R8 active before shutdown", 2'b10, 1, 1, 0);
    @(negedge ref_clk) shdn_n = 1'b0;
    step(2);
    expect_out("R8 shutdown overrides active", 2'b00, 0, 0, 1);
    step(10);
    expect_out("R1 shutdown ignores running clock", 2'b00, 0, 0, 1);
    @(negedge ref_clk) shdn_n = 1'b1;
    step(3);
    expect_out("R8 restart standby, detector clear", 2'b01, 0, 0, 1);
    wait_det(1'b1, n);
    check_cond("R8 redetect latency", n > 0 && n <= LIMIT, n, LIMIT);
    step(HOLD + 1);
    expect_out("R8 active again", 2'b10, 1, 1, 0);

    step(5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * REF_PERIOD);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule